// File: doc/BRIEF.md
# Quasi-Random Test Pattern Generator

This block produces a serial test bit stream, one bit for each cycle in which `en_i` is high. The default pattern comes from a 20-stage maximal-length feedback shift register. Its period is 1,048,575 bits. A zero-run limiter follows the register. It forces the output to 1 whenever the next 14 bits waiting to leave the register are all zero. The limiter acts on the output bit only, so the register sequence itself is unchanged.

A second pattern source repeats a programmable user code of up to 32 bits. `sel_i` chooses between the two sources. Only the selected source advances, so a source that is switched away from resumes where it stopped. `start_o` marks the bit that begins each pattern period. Downstream logic uses it to frame error counts or to trigger a scope. The register width, the feedback tap and the zero-run length are parameters. A small instance can therefore be checked over complete periods.

Top module: `qrs_gen`

## Requirements
- R1: When reset is released, the shift register holds all ones and the user code position is 0. With `sel_i`=0, `data_o`=1 and `start_o`=1.
- R2: With `sel_i`=0 and `en_i`=1, each clock shifts the register one stage. Stage k takes stage k-1, and stage 1 takes stage 17 XOR stage 20. The register never reaches all zeros, and its period is 2^20-1.
- R3: With `sel_i`=0, `data_o` is stage 20 without inversion. It is forced to 1 when stages 6 through 19, which are the next 14 output bits, are all zero. This forcing does not change the register contents.
- R4: With `sel_i`=0, `start_o` is high exactly while the register equals its all-ones seed.
- R5: With `sel_i`=1, `data_o` is `code_i[L-1-k]`, where L is the effective length and k is the position. The code is therefore sent MSB first from bit L-1. If k is L or more, `code_i[0]` is sent.
- R6: The effective length L is 1 when `len_i` is 0 and 32 when `len_i` is above 32. Otherwise L equals `len_i`.
- R7: With `sel_i`=1 and `en_i`=1, the position k advances by one each clock. It returns to 0 when k is L-1 or more.
- R8: With `sel_i`=1, `start_o` is high exactly while k is 0.
- R9: While `en_i` is low, neither the register nor the position changes, so `data_o` and `start_o` hold.
- R10: Only the selected source advances. The other source keeps its state across mode switches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the selected source by one bit |
| sel_i | input | 1 | 0: shift-register pattern, 1: user code |
| code_i | input | 32 | User code word |
| len_i | input | 6 | User code length in bits |
| data_o | output | 1 | Serial test bit |
| start_o | output | 1 | High on the first bit of a pattern period |

## Verification
Three behaviours are hard to reach from the ports: the wrap back to the seed, the zero-run forcing, and a long run of the full-size register. A full period of the default register is far beyond any practical run. The bench therefore adds a second instance with a 5-stage register, a tap at stage 3 and a 2-bit look-ahead. That instance wraps every 31 bits and meets a forced bit several times per period. Both instances share stimulus with the default instance over 120,000 enabled and paused cycles. A scoreboard then checks every bit, every period mark and every paused cycle against models built from the requirements. User-code runs then shorten the length below the current position, use length 0, and use lengths above 32.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  typedef enum logic {
    PAT_QRS  = 1'b0,
    PAT_USER = 1'b1
  } pat_sel_e;
endpackage

// File: rtl/qrs_lfsr.sv
module qrs_lfsr #(
  parameter int unsigned W    = 20,
  parameter int unsigned TAP  = 17,
  parameter int unsigned ZRUN = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o,
  output logic         bit_o,
  output logic         start_o
);
  localparam logic [W-1:0] SEED = '1;

  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= SEED;
    else if (step_i) sr_q <= {sr_q[W-2:0], sr_q[TAP-1] ^ sr_q[W-1]};
  end

  // look-ahead spans the ZRUN stages feeding the output stage
  generate
    if (ZRUN > 0) begin : g_sup
      logic run_zero;
      assign run_zero = (sr_q[W-2 -: ZRUN] == '0);
      assign bit_o    = sr_q[W-1] | run_zero;
    end else begin : g_raw
      assign bit_o = sr_q[W-1];
    end
  endgenerate

  assign start_o = (sr_q == SEED);
  assign state_o = sr_q;
endmodule

// File: rtl/qrs_ucode.sv
module qrs_ucode #(
  parameter int unsigned CW = 32,
  parameter int unsigned LW = $clog2(CW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] code_i,
  input  logic [LW-1:0] len_i,
  output logic [LW-1:0] pos_o,
  output logic [LW-1:0] len_eff_o,
  output logic          bit_o,
  output logic          start_o
);
  localparam int unsigned IW  = $clog2(CW);
  localparam logic [LW-1:0] ONE = LW'(1);
  localparam logic [LW-1:0] MAX = LW'(CW);

  logic [LW-1:0] pos_q, len_eff, idx;

  always_comb begin
    if (len_i == '0)      len_eff = ONE;
    else if (len_i > MAX) len_eff = MAX;
    else                  len_eff = len_i;
  end

  // stale position after a length cut selects bit 0
  assign idx = (pos_q >= len_eff) ? '0 : (len_eff - pos_q - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (step_i) pos_q <= (pos_q >= len_eff - ONE) ? '0 : pos_q + ONE;
  end

  assign bit_o     = code_i[idx[IW-1:0]];
  assign start_o   = (pos_q == '0);
  assign pos_o     = pos_q;
  assign len_eff_o = len_eff;
endmodule

// File: rtl/qrs_gen.sv
module qrs_gen
  import qrs_pkg::*;
#(
  parameter int unsigned W      = 20,
  parameter int unsigned TAP    = 17,
  parameter int unsigned ZRUN   = 14,
  parameter int unsigned CODE_W = 32,
  parameter int unsigned LEN_W  = $clog2(CODE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              data_o,
  output logic              start_o
);
  pat_sel_e sel;
  logic lf_step, uc_step;
  logic lf_bit, lf_start, uc_bit, uc_start;
  logic [W-1:0]     lfsr_state;
  logic [LEN_W-1:0] uc_pos, uc_len;

  assign sel     = pat_sel_e'(sel_i);
  assign lf_step = en_i && (sel == PAT_QRS);
  assign uc_step = en_i && (sel == PAT_USER);

  qrs_lfsr #(.W(W), .TAP(TAP), .ZRUN(ZRUN)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (lf_step),
    .state_o (lfsr_state),
    .bit_o   (lf_bit),
    .start_o (lf_start)
  );

  qrs_ucode #(.CW(CODE_W), .LW(LEN_W)) u_ucode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (uc_step),
    .code_i    (code_i),
    .len_i     (len_i),
    .pos_o     (uc_pos),
    .len_eff_o (uc_len),
    .bit_o     (uc_bit),
    .start_o   (uc_start)
  );

  always_comb begin
    if (sel == PAT_USER) begin
      data_o  = uc_bit;
      start_o = uc_start;
    end else begin
      data_o  = lf_bit;
      start_o = lf_start;
    end
  end
endmodule

// File: rtl/qrs_gen_chk.sv
module qrs_gen_chk #(
  parameter int unsigned W   = 20,
  parameter int unsigned TAP = 17,
  parameter int unsigned LW  = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          sel_i,
  input logic          data_o,
  input logic [W-1:0]  lfsr_state,
  input logic [LW-1:0] uc_pos,
  input logic [LW-1:0] uc_len
);
  // R9
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(lfsr_state) && $stable(uc_pos));

  // R2
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sel_i) |=> (lfsr_state[W-1:1] == $past(lfsr_state[W-2:0])) &&
      (lfsr_state[0] == ($past(lfsr_state[TAP-1]) ^ $past(lfsr_state[W-1]))));

  // R2
  never_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != '0);

  // R3
  out_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && lfsr_state[W-1]) |-> data_o);

  // R10
  lfsr_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_i) |=> $stable(lfsr_state));

  // R10
  ucode_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sel_i) |=> $stable(uc_pos));

  // R7
  pos_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_i && (uc_pos >= uc_len - LW'(1))) |=> (uc_pos == '0));
endmodule

bind qrs_gen qrs_gen_chk #(.W(W), .TAP(TAP), .LW(LEN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .sel_i      (sel_i),
  .data_o     (data_o),
  .lfsr_state (lfsr_state),
  .uc_pos     (uc_pos),
  .uc_len     (uc_len)
);

// File: tb/qrs_gen_tb.sv
`timescale 1ns/1ps
module qrs_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sel = 1'b0;
  logic [31:0] code = '0;
  logic [5:0]  len = '0;
  logic d_big, s_big, d_sml, s_sml;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  // models from the requirements
  logic [19:0] mb = '1;
  logic [4:0]  ms = '1;
  int          uk = 0;
  int          sml_forced = 0;

  always #4 clk = ~clk;

  qrs_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sel_i(sel),
    .code_i(code), .len_i(len), .data_o(d_big), .start_o(s_big)
  );

  qrs_gen #(.W(5), .TAP(3), .ZRUN(2)) u_small (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sel_i(sel),
    .code_i(code), .len_i(len), .data_o(d_sml), .start_o(s_sml)
  );

  function automatic int eff_len(input logic [5:0] l);
    if (l == 0) return 1;
    if (l > 32) return 32;
    return int'(l);
  endfunction

  task automatic step(input logic e, input logic s, input logic [31:0] c,
                      input logic [5:0] l, input string tag);
    logic [3:0] x;
    int L, bi;
    @(negedge clk);
    en = e; sel = s; code = c; len = l;
    L = eff_len(l);
    if (s) begin
      bi = (uk >= L) ? 0 : L - 1 - uk;
      x = {c[bi], uk == 0, c[bi], uk == 0};
    end else begin
      x[3] = mb[19] | (mb[18:5] == 14'd0);
      x[2] = (mb == 20'hFFFFF);
      x[1] = ms[4] | (ms[3:2] == 2'd0);
      x[0] = (ms == 5'h1F);
      if (!ms[4] && x[1]) sml_forced++;
    end
    exp_q.push_back(x);
    tag_q.push_back(tag);
    if (e) begin
      if (s) uk = (uk >= L - 1) ? 0 : uk + 1;
      else begin
        mb = {mb[18:0], mb[16] ^ mb[19]};
        ms = {ms[3:0], ms[2] ^ ms[4]};
      end
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {d_big, s_big, d_sml, s_sml};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: {data,start,small_data,small_start} actual %b expected %b at %0t",
                 t, a, e, $time);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 seed state
    step(1'b0, 1'b0, 32'h0, 6'd0, "R1");
    step(1'b0, 1'b1, 32'h8000_0000, 6'd32, "R1 R8");
    // R2 R3 R4 long run with pauses (R9)
    for (int i = 0; i < 120000; i++) begin
      if ((i % 1000) >= 995) step(1'b0, 1'b0, 32'h0, 6'd0, "R9");
      else step(1'b1, 1'b0, 32'h0, 6'd0, "R2 R3 R4");
    end
    // R5 R7 R8 full-width code
    for (int i = 0; i < 70; i++) step(1'b1, 1'b1, 32'hA5C3_0F1E, 6'd32, "R5 R7 R8");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 32'hA5C3_0F1E, 6'd32, "R9");
    // R10 switch away and back
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 32'hA5C3_0F1E, 6'd32, "R10");
    step(1'b1, 1'b1, 32'hA5C3_0F1E, 6'd32, "R10");
    // R7 length cut below the current position
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 32'h0000_0013, 6'd5, "R5 R7");
    // R6 length 0, length 1, length above 32
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 32'hFFFF_FFFD, 6'd0, "R6");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 32'h0000_0001, 6'd1, "R6");
    for (int i = 0; i < 66; i++) step(1'b1, 1'b1, 32'h8000_0001, 6'd40, "R6 R7");
    step(1'b0, 1'b0, 32'h0, 6'd0, "R10");
    repeat (3) @(negedge clk);
    // R3 small instance met forced bits
    checks++;
    if (sml_forced == 0) begin
      fails++;
      $display("FAIL R3: forced bits seen actual %0d expected >0", sml_forced);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule